// File: doc/BRIEF.md
# Register Write-Protection Key Guard

This block decides whether software may write a group of protected configuration registers. The protected bank stays closed until software writes a two-byte key, 0xCA followed by 0x53, to one dedicated key register. The guard watches the register bus for writes to that address and follows the key through a three-state machine: locked, first byte seen, and open. Any unexpected value written to the key register closes the guard again. Writes to every other address pass by without effect.

A second gate sits on top of the key. The backup-domain write-enable bit comes in from outside and resets to 0. Protected writes are permitted only while the guard is open and that bit is 1. While the bit is 0, even writes to the key register are ignored.

The surrounding register file uses `wr_permit` to qualify its own write strobes. It can also read `key_locked` as the lock status. A backup-domain reset asserts asynchronously and clears all key progress. The reset is released synchronously.

Top module: `wp_key_guard`

## Requirements
- R1: While `rst_bd_n` is low, `wr_permit` is 0 and `key_locked` is 1 immediately, without waiting for a clock edge. Any partial key progress is discarded, so a lone 0x53 written after reset does not open the guard.
- R2: Open the guard with a write of 0xCA and then a write of 0x53, both to address `KEY_ADDR` with `wr_stb` and `bd_wr_en` high. `wr_permit` and `key_locked` show the open state from the clock edge that samples the 0x53 write.
- R3: A strobed write to any address other than `KEY_ADDR` never changes the key state, whether it comes before, between or after the key bytes.
- R4: During the sequence, any value written to the key register other than the byte expected next returns the guard to locked, with no progress kept. This covers 0x53 as the first byte and a repeated 0xCA as the second byte.
- R5: While open, writing 0xCA or 0x53 to the key register keeps the guard open, and writing any other value relocks it.
- R6: Key values are matched against the whole `wr_data` word with the key byte zero-extended, so any nonzero upper bit makes the write a wrong key.
- R7: `wr_permit` equals (guard open) AND `bd_wr_en`, and follows `bd_wr_en` combinationally.
- R8: While `bd_wr_en` is 0, writes to the key register are ignored: key progress and the open state both survive them.
- R9: Bus cycles with `wr_stb` low have no effect on the key state.
- R10: `key_locked` is 0 exactly when the guard is open, independent of `bd_wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-bus clock |
| rst_bd_n | input | 1 | Backup-domain reset, active low, asynchronous assert |
| bd_wr_en | input | 1 | Backup-domain write-enable bit (0 after reset) |
| wr_stb | input | 1 | Register-bus write strobe |
| wr_addr | input | ADDR_W | Register-bus write address |
| wr_data | input | DATA_W | Register-bus write data |
| wr_permit | output | 1 | Protected-register write permit |
| key_locked | output | 1 | Lock status, 1 while the guard is not open |

## Verification
The half-way state, where the first key byte has been seen, is not visible at the ports. If that state is wrong, the error shows one key write later, when a following 0x53 either opens a guard it should not open or fails to open it. For that reason the vectors always follow a suspect write with the write that would expose it. A wrong open or locked state shows on `key_locked` in the very cycle after the offending write. A missing write-enable gate shows the moment `bd_wr_en` drops while the guard is open.

// File: rtl/wp_key_pkg.sv
package wp_key_pkg;

  typedef enum logic [1:0] {
    WK_LOCKED = 2'd0,
    WK_HALF   = 2'd1,
    WK_OPEN   = 2'd2
  } wk_state_e;

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  // assert asynchronously, release through STAGES flops
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/wp_key_decode.sv
module wp_key_decode #(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 32,
  parameter int               KEY_W      = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h5C,
  parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0]  KEY_SECOND = 8'h53
) (
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bd_wr_en,
  output logic              key_wr,
  output logic              is_first,
  output logic              is_second
);

  localparam int PAD_W = DATA_W - KEY_W;

  logic upper_zero;

  generate
    if (PAD_W > 0) begin : g_pad
      assign upper_zero = ~|wr_data[DATA_W-1:KEY_W];
    end else begin : g_nopad
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign key_wr    = wr_stb & bd_wr_en & (wr_addr == KEY_ADDR);
  assign is_first  = upper_zero & (wr_data[KEY_W-1:0] == KEY_FIRST);
  assign is_second = upper_zero & (wr_data[KEY_W-1:0] == KEY_SECOND);

endmodule

// File: rtl/wp_key_fsm.sv
module wp_key_fsm
  import wp_key_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      key_wr,
  input  logic      is_first,
  input  logic      is_second,
  output wk_state_e state_q
);

  wk_state_e state_d;

  always_comb begin
    state_d = WK_LOCKED;
    unique case (state_q)
      WK_LOCKED: state_d = is_first  ? WK_HALF : WK_LOCKED;
      WK_HALF:   state_d = is_second ? WK_OPEN : WK_LOCKED;
      WK_OPEN:   state_d = (is_first | is_second) ? WK_OPEN : WK_LOCKED;
      default:   state_d = WK_LOCKED;
    endcase
  end

  // clock enable: only a qualified key-register write moves the state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= WK_LOCKED;
    else if (key_wr) state_q <= state_d;
  end

endmodule

// File: rtl/wp_key_guard.sv
module wp_key_guard
  import wp_key_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                KEY_W      = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h5C,
  parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0]  KEY_SECOND = 8'h53,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_bd_n,
  input  logic              bd_wr_en,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_permit,
  output logic              key_locked
);

  logic      rst_n;
  logic      key_wr;
  logic      is_first;
  logic      is_second;
  wk_state_e state_q;
  logic      open;

  wp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_bd_n),
    .rst_n_o (rst_n)
  );

  wp_key_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_dec (
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .bd_wr_en  (bd_wr_en),
    .key_wr    (key_wr),
    .is_first  (is_first),
    .is_second (is_second)
  );

  wp_key_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (key_wr),
    .is_first  (is_first),
    .is_second (is_second),
    .state_q   (state_q)
  );

  assign open       = (state_q == WK_OPEN);
  assign wr_permit  = open & bd_wr_en;
  assign key_locked = ~open;

endmodule

// File: rtl/wp_key_guard_chk.sv
module wp_key_guard_chk
  import wp_key_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                KEY_W      = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h5C,
  parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0]  KEY_SECOND = 8'h53
) (
  input logic              clk,
  input logic              rst_bd_n,
  input logic              bd_wr_en,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_permit,
  input logic              key_locked,
  input wk_state_e         state_q
);

  localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

  logic hit_key;
  assign hit_key = wr_stb && bd_wr_en && (wr_addr == KEY_ADDR);

  // R1: reset holds the guard closed
  always @(posedge clk) begin
    if (!rst_bd_n) begin
      p_reset_closed_r1: assert (key_locked && !wr_permit)
        else $error("guard open during reset");
    end
  end

  // R2: second key byte from the half state opens
  p_second_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_bd_n)
    (state_q == WK_HALF && hit_key && wr_data == K2) |=> (state_q == WK_OPEN));

  // R2: the open state is only reached through the second key byte
  p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_bd_n)
    (state_q != WK_OPEN && !(state_q == WK_HALF && hit_key && wr_data == K2))
      |=> (state_q != WK_OPEN));

  // R3: other addresses leave the state alone
  p_other_addr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_bd_n)
    (wr_stb && wr_addr != KEY_ADDR) |=> $stable(state_q));

  // R4 and R5: a non-key value to the key register relocks
  p_bad_value_relocks_r4: assert property (@(posedge clk) disable iff (!rst_bd_n)
    (hit_key && wr_data != K1 && wr_data != K2) |=> (state_q == WK_LOCKED));

  // R7: permit requires both the open state and the enable bit
  p_permit_gated_r7: assert property (@(posedge clk) disable iff (!rst_bd_n)
    wr_permit |-> (bd_wr_en && !key_locked));

  // R8: disabled writes are ignored
  p_disabled_ignored_r8: assert property (@(posedge clk) disable iff (!rst_bd_n)
    !bd_wr_en |=> $stable(state_q));

  // R9: no strobe, no movement
  p_no_stb_stable_r9: assert property (@(posedge clk) disable iff (!rst_bd_n)
    !wr_stb |=> $stable(state_q));

endmodule

bind wp_key_guard wp_key_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
  .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk        (clk),
  .rst_bd_n   (rst_bd_n),
  .bd_wr_en   (bd_wr_en),
  .wr_stb     (wr_stb),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_permit  (wr_permit),
  .key_locked (key_locked),
  .state_q    (state_q)
);

// File: tb/wp_key_guard_tb.sv
module wp_key_guard_tb;

  localparam int          ADDR_W = 8;
  localparam int          DATA_W = 32;
  localparam logic [7:0]  KADDR  = 8'h5C;
  localparam logic [7:0]  OADDR  = 8'h5D;
  localparam int          NVEC   = 17;

  // {en, stb, sel_key_addr, data[7:0], exp_permit, exp_locked}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},  // idle, enabled       R9
    {1'b1, 1'b1, 1'b1, 8'hCA, 1'b0, 1'b1},  // first key           R2
    {1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b1},  // other reg between   R3
    {1'b1, 1'b1, 1'b1, 8'h53, 1'b1, 1'b0},  // second key opens    R2
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // enable low          R7 R10
    {1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},  // disabled bad write  R8
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},  // enable back         R7
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // other reg after     R3
    {1'b1, 1'b1, 1'b1, 8'hCA, 1'b1, 1'b0},  // key value in open   R5
    {1'b1, 1'b1, 1'b1, 8'h77, 1'b0, 1'b1},  // non-key relocks     R5
    {1'b1, 1'b1, 1'b1, 8'h53, 1'b0, 1'b1},  // wrong order         R4
    {1'b1, 1'b1, 1'b1, 8'hCA, 1'b0, 1'b1},  // first key           R4
    {1'b1, 1'b1, 1'b1, 8'hCA, 1'b0, 1'b1},  // repeated first      R4
    {1'b1, 1'b1, 1'b1, 8'hCA, 1'b0, 1'b1},  // first key again     R4
    {1'b0, 1'b1, 1'b1, 8'h11, 1'b0, 1'b1},  // disabled, keep half R8
    {1'b1, 1'b1, 1'b1, 8'h53, 1'b1, 1'b0},  // opens               R8
    {1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0}   // no strobe           R9
  };

  logic              clk = 1'b0;
  logic              rst_bd_n;
  logic              bd_wr_en;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_permit;
  logic              key_locked;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wp_key_guard u_dut (
    .clk        (clk),
    .rst_bd_n   (rst_bd_n),
    .bd_wr_en   (bd_wr_en),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_permit  (wr_permit),
    .key_locked (key_locked)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(input logic en, input logic stb, input logic [7:0] a,
                      input logic [DATA_W-1:0] d);
    bd_wr_en = en;
    wr_stb   = stb;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
  endtask

  task automatic reset_pulse();
    rst_bd_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_bd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_bd_n = 1'b0;
    bd_wr_en = 1'b1;
    wr_stb   = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset permit", wr_permit, 1'b0);
    chk("R1 reset locked", key_locked, 1'b1);
    rst_bd_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10] ? KADDR : OADDR,
           DATA_W'(VEC[i][9:2]));
      chk($sformatf("vector %0d permit (R2-R10 table)", i), wr_permit, VEC[i][1]);
      chk($sformatf("vector %0d locked (R2-R10 table)", i), key_locked, VEC[i][0]);
    end

    // R6: upper data bits set make 0xCA a wrong key, relocking the open guard
    step(1'b1, 1'b1, KADDR, 32'h0000_01CA);
    chk("R6 upper bits relock", key_locked, 1'b1);
    step(1'b1, 1'b1, KADDR, 32'h8000_00CA);
    step(1'b1, 1'b1, KADDR, 32'h0000_0053);
    chk("R6 upper bits no first key", key_locked, 1'b1);

    // R1: progress discarded by reset
    step(1'b1, 1'b1, KADDR, 32'h0000_00CA);
    wr_stb = 1'b0;
    reset_pulse();
    step(1'b1, 1'b1, KADDR, 32'h0000_0053);
    chk("R1 progress cleared", key_locked, 1'b1);

    // R1: asynchronous close while open
    step(1'b1, 1'b1, KADDR, 32'h0000_00CA);
    step(1'b1, 1'b1, KADDR, 32'h0000_0053);
    chk("R2 reopen", wr_permit, 1'b1);
    wr_stb = 1'b0;
    #2;
    rst_bd_n = 1'b0;
    #1;
    chk("R1 async permit", wr_permit, 1'b0);
    chk("R10 async locked", key_locked, 1'b1);
    @(negedge clk);
    rst_bd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset locked", key_locked, 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule